// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block keeps the register-page selector of a small processor core in a three-level hardware stack. The top level is the page in use and drives the page-select output that decodes register-space accesses. When the core takes an interrupt, the top level is loaded with the page the interrupting peripheral needs, and the older pages move one level deeper. When the handler returns, they move back up. A higher-priority interrupt that arrives during a lower-priority handler simply pushes a second time.

Software reaches all three levels and a control register through a small register port. Reads are combinational and writes take effect on the next clock edge. A control bit, set by reset, turns the automatic push and pop on or off. Priority arbitration, vectoring and the core itself are outside the block.

Top module: `pgstk_top`

## Requirements
- R1: After reset the top, middle and bottom levels all read 0x00, page_sel is 0x00 and the control register (address 3, bit 0 = auto-stack enable) reads 0x01.
- R2: With auto-stack enabled, a cycle with irq_enter high makes, from the next cycle on, top = irq_page, middle = the previous top and bottom = the previous middle.
- R3: With auto-stack enabled, a cycle with irq_return high and irq_enter low makes, from the next cycle on, top = the previous middle and middle = the previous bottom, while bottom keeps its value.
- R4: Two interrupt entries in a row (a nested higher-priority interrupt) stack both pages, so the first vectored page sits in the middle level under the second.
- R5: A cycle with reg_wr high and no hardware push or pop writes reg_wdata into the level selected by reg_addr (0 = top, 1 = middle, 2 = bottom) or, at address 3, writes bit 0 into the enable; reg_rdata shows the addressed register in the same cycle, with bits 7..1 of address 3 reading zero.
- R6: When a push or pop happens in the same cycle as a register write, the hardware action takes place and the write is discarded.
- R7: When irq_enter and irq_return are both high in one cycle with auto-stack enabled, a push is performed and no pop.
- R8: With the enable bit cleared, irq_enter and irq_return leave all three levels unchanged, and register writes to the levels still work.
- R9: page_sel always equals the value of the top level.
- R10: A value software wrote into the bottom level is lost on the next push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enter | input | 1 | One-cycle strobe: interrupt taken |
| irq_return | input | 1 | One-cycle strobe: interrupt handler returned |
| irq_page | input | 8 | Page needed by the interrupt being taken |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 top, 1 middle, 2 bottom, 3 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| page_sel | output | 8 | Active page, taken from the top level |

## Verification
A wrong shift direction or a dropped level shows on page_sel one cycle after the push or pop that caused it, and the three read addresses show which level holds the wrong value. A write that wrongly beats a same-cycle push shows as the written value on page_sel in place of irq_page on the very next cycle. An enable that is ignored shows as page_sel moving after a strobe while control reads zero; a stale bottom level only surfaces after a pop brings it up to the middle level, two reads later.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2
  } stk_act_e;

  // Hardware action chosen for one cycle; entry has priority over return.
  function automatic stk_act_e pick_action(input logic enter, input logic ret,
                                           input logic en);
    if (!en)        return ACT_HOLD;
    else if (enter) return ACT_PUSH;
    else if (ret)   return ACT_POP;
    else            return ACT_HOLD;
  endfunction

endpackage

// File: rtl/pgstk_decode.sv
module pgstk_decode import pgstk_pkg::*; #(
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              auto_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              push_ev,
  output logic              pop_ev,
  output logic [DEPTH-1:0]  lvl_we,
  output logic              ctl_we
);

  stk_act_e act;
  logic     sw_ok;

  always_comb begin
    act     = pick_action(irq_enter, irq_return, auto_en);
    push_ev = (act == ACT_PUSH);
    pop_ev  = (act == ACT_POP);
    sw_ok   = reg_wr && (act == ACT_HOLD);
    ctl_we  = sw_ok && (int'(reg_addr) == DEPTH);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign lvl_we[i] = sw_ok && (int'(reg_addr) == i);
  end

  // R6: at most one kind of update per cycle
  always_comb begin
    a_r6_one_update: assert ($onehot0({push_ev, pop_ev, |lvl_we, ctl_we}));
  end

endmodule

// File: rtl/pgstk_levels.sv
module pgstk_levels #(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_ev,
  input  logic                          pop_ev,
  input  logic [PAGE_W-1:0]             push_page,
  input  logic [DEPTH-1:0]              lvl_we,
  input  logic [PAGE_W-1:0]             wdata,
  output logic [DEPTH-1:0][PAGE_W-1:0]  lvl
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [PAGE_W-1:0] from_above;
    logic [PAGE_W-1:0] from_below;

    if (i == 0) begin : g_top
      assign from_above = push_page;
    end else begin : g_deeper
      assign from_above = lvl[i-1];
    end

    if (i == DEPTH - 1) begin : g_bottom
      assign from_below = lvl[i];
    end else begin : g_upper
      assign from_below = lvl[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         lvl[i] <= '0;
      else if (push_ev)   lvl[i] <= from_above;
      else if (pop_ev)    lvl[i] <= from_below;
      else if (lvl_we[i]) lvl[i] <= wdata;
    end
  end

  // R2: push loads the vectored page and shifts down
  a_r2_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (lvl[0] == $past(push_page)) && (lvl[1] == $past(lvl[0]))
                && (lvl[2] == $past(lvl[1])));

  // R3: pop shifts up and the bottom keeps its value
  a_r3_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (lvl[0] == $past(lvl[1])) && (lvl[1] == $past(lvl[2]))
               && $stable(lvl[2]));

  // R8: no event and no write leaves the stack unchanged
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ev && !pop_ev && (lvl_we == '0)) |=> $stable(lvl));

endmodule

// File: rtl/pgstk_top.sv
module pgstk_top import pgstk_pkg::*; #(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  localparam int ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic [PAGE_W-1:0] irq_page,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  output logic [PAGE_W-1:0] page_sel
);

  logic                         auto_en;
  logic                         push_ev;
  logic                         pop_ev;
  logic                         ctl_we;
  logic [DEPTH-1:0]             lvl_we;
  logic [DEPTH-1:0][PAGE_W-1:0] lvl;

  pgstk_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dec (
    .irq_enter (irq_enter),
    .irq_return(irq_return),
    .auto_en   (auto_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .push_ev   (push_ev),
    .pop_ev    (pop_ev),
    .lvl_we    (lvl_we),
    .ctl_we    (ctl_we)
  );

  pgstk_levels #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_ev  (push_ev),
    .pop_ev   (pop_ev),
    .push_page(irq_page),
    .lvl_we   (lvl_we),
    .wdata    (reg_wdata),
    .lvl      (lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      auto_en <= 1'b1;
    else if (ctl_we) auto_en <= reg_wdata[0];
  end

  always_comb begin
    if (int'(reg_addr) < DEPTH) reg_rdata = lvl[reg_addr];
    else                        reg_rdata = {{(PAGE_W-1){1'b0}}, auto_en};
  end

  assign page_sel = lvl[0];

  // R6: a push beats a same-cycle write to the top level
  a_r6_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && auto_en && reg_wr) |=> (page_sel == $past(irq_page)));

  // R8: strobes with the enable cleared and no write leave page_sel alone
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_enter || irq_return) && !auto_en && !reg_wr) |=> $stable(page_sel));

  // R7: simultaneous strobes push
  a_r7_enter_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && irq_return && auto_en) |=> (page_sel == $past(irq_page)));

endmodule

// File: tb/sim_pgstk_top.sv
`timescale 1ns/100ps
module sim_pgstk_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_enter, irq_return, reg_wr;
  logic [7:0] irq_page, reg_wdata;
  logic [1:0] reg_addr;
  logic [7:0] reg_rdata, page_sel;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] m [3];
  logic       men;

  always #2 clk = ~clk;

  pgstk_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter), .irq_return(irq_return),
    .irq_page(irq_page), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_sel(page_sel)
  );

  task automatic cmp(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Reads every register through the port and compares with the model.
  task automatic check_state(input string req);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #0.3;
      if (a < 3) cmp(req, $sformatf("level %0d", a), reg_rdata, m[a]);
      else       cmp(req, "control", reg_rdata, {7'b0, men});
    end
    cmp(req, "page_sel (R9)", page_sel, m[0]);
  endtask

  // One clock cycle of stimulus; the model applies the spec rules.
  task automatic step(input logic en_i, input logic ret_i, input logic [7:0] pg,
                      input logic wr_i, input logic [1:0] ad, input logic [7:0] wd,
                      input string req);
    @(negedge clk);
    irq_enter = en_i; irq_return = ret_i; irq_page = pg;
    reg_wr = wr_i; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    #1;
    irq_enter = 0; irq_return = 0; reg_wr = 0;
    if (men && en_i) begin
      m[2] = m[1]; m[1] = m[0]; m[0] = pg;
    end else if (men && ret_i) begin
      m[0] = m[1]; m[1] = m[2];
    end else if (wr_i) begin
      if (ad < 3) m[ad] = wd;
      else        men  = wd[0];
    end
    check_state(req);
  endtask

  task automatic t_reset;
    check_state("R1");
  endtask

  task automatic t_write;
    step(0, 0, 8'h00, 1, 2'd0, 8'h11, "R5");
    step(0, 0, 8'h00, 1, 2'd1, 8'h22, "R5");
    step(0, 0, 8'h00, 1, 2'd2, 8'h33, "R5");
    cmp("R5", "top value", m[0], 8'h11);
  endtask

  task automatic t_push;
    step(1, 0, 8'h05, 0, 2'd0, 8'h00, "R2");
    cmp("R10", "bottom after push", m[2], 8'h22);
    step(1, 0, 8'h0F, 0, 2'd0, 8'h00, "R4");
    cmp("R4", "middle holds first page", m[1], 8'h05);
  endtask

  task automatic t_pop;
    step(0, 1, 8'h00, 0, 2'd0, 8'h00, "R3");
    step(0, 1, 8'h00, 0, 2'd0, 8'h00, "R3");
    cmp("R3", "bottom kept", m[2], 8'h11);
  endtask

  task automatic t_conflict;
    step(0, 0, 8'h00, 1, 2'd2, 8'h5A, "R5");
    step(1, 0, 8'h40, 1, 2'd0, 8'hAA, "R6");
    step(0, 1, 8'h00, 1, 2'd2, 8'h77, "R6");
    step(1, 1, 8'h66, 0, 2'd0, 8'h00, "R7");
  endtask

  task automatic t_disable;
    step(0, 0, 8'h00, 1, 2'd3, 8'h00, "R8");
    step(1, 0, 8'h99, 0, 2'd0, 8'h00, "R8");
    step(0, 1, 8'h00, 0, 2'd0, 8'h00, "R8");
    step(0, 0, 8'h00, 1, 2'd1, 8'hC3, "R8");
    step(0, 0, 8'h00, 1, 2'd3, 8'hFF, "R5");
    step(1, 0, 8'h21, 0, 2'd0, 8'h00, "R2");
  endtask

  initial begin
    rst_n = 0; irq_enter = 0; irq_return = 0; irq_page = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m[0] = 0; m[1] = 0; m[2] = 0; men = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_write();
    t_push();
    t_pop();
    t_conflict();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule